// File: doc/BRIEF.md
# Indexed Colour Palette Register Interface

This block holds a 256-entry colour lookup table for a pseudo-colour display pipe, along with the small host register port used to load and inspect it. The host selects one of four word registers: index, palette data, control and cursor. The data byte for every register is carried in the most significant byte of a 32-bit bus word. To load a palette entry, the host writes the index register and then makes three palette-data writes, one for each component, in the order red, green, blue. A phase sequencer routes each access to the correct component. After blue, the sequencer moves the index on to the next entry.

Palette-data reads use the same three-step order and advance the index in the same way. The control registers form a small indexed space that shares the same index register and is reached through the control port. One control slot is the plane read mask. On the display side, an 8-bit pixel index is ANDed with that mask, looked up in the table, and returned as a 24-bit colour one clock later.

Top module: `clut_regif`

## Requirements
- R1: After reset, the index is 0 and the phase is red. Control slot 4 (read mask) holds 0xFF, slot 6 holds 0x73, and all other control slots hold 0x00. The cursor register is 0x00, `pix_rgb` is 0 and `host_rvalid` is low.
- R2: `host_sel` encodes 0 = index, 1 = palette data, 2 = control, 3 = cursor. Write data is taken from `host_wdata[31:24]` only. An accepted read returns its byte in `host_rdata[31:24]` with bits 23:0 zero, one cycle later, with `host_rvalid` high for that cycle. `host_rdata` holds its value between reads.
- R3: A write to the index register loads the index from the data byte and returns the phase to red, even in the middle of a red/green/blue sequence.
- R4: Palette-data writes store red, then green, then blue into the entry at the current index. After the blue access, the index increments by one, wrapping from 255 to 0, and the phase returns to red.
- R5: Palette-data reads return red, then green, then blue of the current entry. They advance the phase and index exactly as writes do.
- R6: Control-port writes and reads address the control slot selected by the current index. Only indices 0 to 7 exist. A write at a higher index changes nothing, and a read there returns 0. Control and cursor accesses do not move the index or the phase.
- R7: `pix_rgb` equals `{red, green, blue}` of the entry at `pix_idx & mask`, where `pix_idx` is sampled on the previous clock edge.
- R8: The read mask is control slot 4. A mask write affects lookups sampled on later edges, not the lookup sampled on the same edge as the write.
- R9: When a palette-data write and a pixel lookup hit the same entry on the same edge, the lookup returns the value before the write. The next lookup returns the written value.
- R10: When `host_wr` and `host_rd` are both high, only the write takes effect. No read is performed and `host_rvalid` stays low.
- R11: The cursor register stores the written byte and returns it on a cursor read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_sel | input | 2 | Register select (0 index, 1 palette data, 2 control, 3 cursor) |
| host_wdata | input | 32 | Write word; the byte is in bits 31:24 |
| host_rdata | output | 32 | Read word; the byte is in bits 31:24 |
| host_rvalid | output | 1 | High one cycle after an accepted read |
| pix_idx | input | 8 | Pixel colour index |
| pix_rgb | output | 24 | Looked-up colour, registered |

## Verification
Two pairs of functions can coincide on one clock edge.

The first pair is a host palette-data write and a pixel lookup of the same entry. The bench holds `pix_idx` on an entry while the red byte of that entry is rewritten. It then expects the pre-write colour on the following cycle and the new colour one cycle after that.

The second pair is a read-mask write and a lookup sampled on the same edge. Here the old mask must still apply.

A cycle-level reference model in the bench decides all of these outcomes. The bench also drives simultaneous write and read strobes and requires that only the write is observed.

// File: rtl/clut_pkg.sv
package clut_pkg;

    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_t;

    typedef enum logic [1:0] {
        SEL_INDEX = 2'd0,
        SEL_PAL   = 2'd1,
        SEL_CTRL  = 2'd2,
        SEL_CURS  = 2'd3
    } regsel_t;

    localparam int unsigned NUM_COMP = 3;

endpackage

// File: rtl/clut_seq.sv
module clut_seq
    import clut_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    input  logic             step,
    output logic [IDX_W-1:0] idx,
    output phase_t           phase
);

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        phase_t           phase;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.idx   = load_val;
            st_d.phase = PH_RED;
        end else if (step) begin
            unique case (st_q.phase)
                PH_RED:  st_d.phase = PH_GRN;
                PH_GRN:  st_d.phase = PH_BLU;
                default: begin
                    st_d.phase = PH_RED;
                    st_d.idx   = st_q.idx + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{idx: '0, phase: PH_RED};
        end else begin
            st_q <= st_d;
        end
    end

    assign idx   = st_q.idx;
    assign phase = st_q.phase;

endmodule

// File: rtl/clut_lut.sv
module clut_lut
    import clut_pkg::*;
#(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned COMP_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  phase_t                     wr_phase,
    input  logic [COMP_W-1:0]          wr_data,
    input  logic [IDX_W-1:0]           rd_idx,
    input  phase_t                     rd_phase,
    output logic [COMP_W-1:0]          rd_data,
    input  logic [IDX_W-1:0]           pix_idx,
    input  logic [IDX_W-1:0]           pix_mask,
    output logic [NUM_COMP*COMP_W-1:0] pix_rgb
);

    localparam int unsigned DEPTH = 1 << IDX_W;

    logic [IDX_W-1:0]  pix_addr;
    logic [COMP_W-1:0] comp_rd  [NUM_COMP];
    logic [COMP_W-1:0] comp_pix [NUM_COMP];

    assign pix_addr = pix_idx & pix_mask;

    for (genvar c = 0; c < NUM_COMP; c++) begin : g_comp
        logic [COMP_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_phase == phase_t'(c))) begin
                mem[wr_idx] <= wr_data;
            end
        end

        assign comp_rd[c]  = mem[rd_idx];
        assign comp_pix[c] = mem[pix_addr];
    end

    always_comb begin
        unique case (rd_phase)
            PH_RED:  rd_data = comp_rd[0];
            PH_GRN:  rd_data = comp_rd[1];
            default: rd_data = comp_rd[2];
        endcase
    end

    typedef struct packed {
        logic [NUM_COMP*COMP_W-1:0] rgb;
    } pix_st_t;

    pix_st_t px_d, px_q;

    always_comb begin
        px_d.rgb = {comp_pix[0], comp_pix[1], comp_pix[2]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            px_q <= '0;
        end else begin
            px_q <= px_d;
        end
    end

    assign pix_rgb = px_q.rgb;

endmodule

// File: rtl/clut_ctrl.sv
module clut_ctrl #(
    parameter int unsigned IDX_W      = 8,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned DEPTH      = 8,
    parameter int unsigned MASK_SLOT  = 4,
    parameter int unsigned OVL_SLOT   = 6,
    parameter logic [7:0]  MASK_INIT  = 8'hFF,
    parameter logic [7:0]  OVL_INIT   = 8'h73
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              curs_wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctrl_rd,
    output logic [DATA_W-1:0] curs,
    output logic [DATA_W-1:0] mask
);

    localparam int unsigned SLOT_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] slots;
        logic [DATA_W-1:0]            curs;
    } ctrl_st_t;

    function automatic ctrl_st_t reset_state();
        ctrl_st_t s;
        s = '0;
        s.slots[MASK_SLOT] = DATA_W'(MASK_INIT);
        s.slots[OVL_SLOT]  = DATA_W'(OVL_INIT);
        return s;
    endfunction

    localparam ctrl_st_t RST_ST = reset_state();

    ctrl_st_t         cs_d, cs_q;
    logic             in_range;
    logic [SLOT_W-1:0] slot;

    assign in_range = ({1'b0, idx} < (IDX_W+1)'(DEPTH));
    assign slot     = idx[SLOT_W-1:0];

    always_comb begin
        cs_d = cs_q;
        if (ctrl_wr && in_range) begin
            cs_d.slots[slot] = wdata;
        end
        if (curs_wr) begin
            cs_d.curs = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= RST_ST;
        end else begin
            cs_q <= cs_d;
        end
    end

    assign ctrl_rd = in_range ? cs_q.slots[slot] : '0;
    assign curs    = cs_q.curs;
    assign mask    = cs_q.slots[MASK_SLOT];

endmodule

// File: rtl/clut_regif.sv
module clut_regif
    import clut_pkg::*;
#(
    parameter int unsigned IDX_W      = 8,
    parameter int unsigned COMP_W     = 8,
    parameter int unsigned BUS_W      = 32,
    parameter int unsigned CTRL_DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_wr,
    input  logic                       host_rd,
    input  logic [1:0]                 host_sel,
    input  logic [BUS_W-1:0]           host_wdata,
    output logic [BUS_W-1:0]           host_rdata,
    output logic                       host_rvalid,
    input  logic [IDX_W-1:0]           pix_idx,
    output logic [NUM_COMP*COMP_W-1:0] pix_rgb
);

    localparam int unsigned LANE_LSB = BUS_W - COMP_W;

    regsel_t           sel;
    logic [COMP_W-1:0] wr_byte;
    logic              rd_acc;
    logic              idx_load;
    logic              pal_step;
    logic [IDX_W-1:0]  seq_idx;
    phase_t            seq_phase;
    logic [COMP_W-1:0] pal_rd;
    logic [COMP_W-1:0] ctrl_rd;
    logic [COMP_W-1:0] curs_val;
    logic [COMP_W-1:0] mask_val;
    logic [COMP_W-1:0] rd_byte;
    logic              unused_low;

    assign sel        = regsel_t'(host_sel);
    assign wr_byte    = host_wdata[BUS_W-1:LANE_LSB];
    assign unused_low = ^host_wdata[LANE_LSB-1:0];
    assign rd_acc     = host_rd && !host_wr;
    assign idx_load   = host_wr && (sel == SEL_INDEX);
    assign pal_step   = (host_wr || rd_acc) && (sel == SEL_PAL);

    clut_seq #(.IDX_W(IDX_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (idx_load),
        .load_val (IDX_W'(wr_byte)),
        .step     (pal_step),
        .idx      (seq_idx),
        .phase    (seq_phase)
    );

    clut_lut #(.IDX_W(IDX_W), .COMP_W(COMP_W)) u_lut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_wr && (sel == SEL_PAL)),
        .wr_idx   (seq_idx),
        .wr_phase (seq_phase),
        .wr_data  (wr_byte),
        .rd_idx   (seq_idx),
        .rd_phase (seq_phase),
        .rd_data  (pal_rd),
        .pix_idx  (pix_idx),
        .pix_mask (IDX_W'(mask_val)),
        .pix_rgb  (pix_rgb)
    );

    clut_ctrl #(.IDX_W(IDX_W), .DATA_W(COMP_W), .DEPTH(CTRL_DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (host_wr && (sel == SEL_CTRL)),
        .curs_wr (host_wr && (sel == SEL_CURS)),
        .idx     (seq_idx),
        .wdata   (wr_byte),
        .ctrl_rd (ctrl_rd),
        .curs    (curs_val),
        .mask    (mask_val)
    );

    always_comb begin
        unique case (sel)
            SEL_INDEX: rd_byte = COMP_W'(seq_idx);
            SEL_PAL:   rd_byte = pal_rd;
            SEL_CTRL:  rd_byte = ctrl_rd;
            default:   rd_byte = curs_val;
        endcase
    end

    typedef struct packed {
        logic [BUS_W-1:0] rdata;
        logic             rvalid;
    } rd_st_t;

    rd_st_t rd_d, rd_q;

    always_comb begin
        rd_d        = rd_q;
        rd_d.rvalid = rd_acc;
        if (rd_acc) begin
            rd_d.rdata = {rd_byte, {LANE_LSB{1'b0}}};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign host_rdata  = rd_q.rdata;
    assign host_rvalid = rd_q.rvalid;

endmodule

// File: rtl/clut_regif_chk.sv
module clut_regif_chk #(
    parameter int unsigned IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             host_wr,
    input logic             host_rd,
    input logic [1:0]       host_sel,
    input logic             host_rvalid,
    input logic [7:0]       wr_byte,
    input logic [IDX_W-1:0] seq_idx,
    input logic [1:0]       seq_phase
);

    logic pal_acc;
    logic idx_wr;
    assign pal_acc = (host_wr || host_rd) && (host_sel == 2'd1);
    assign idx_wr  = host_wr && (host_sel == 2'd0);

    p_index_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (seq_phase == 2'd0) && (seq_idx == IDX_W'($past(wr_byte))));

    p_wrap_after_blue_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pal_acc && seq_phase == 2'd2) |=>
            (seq_idx == IDX_W'($past(seq_idx) + 1'b1)) && (seq_phase == 2'd0));

    p_read_steps_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && host_sel == 2'd1 && seq_phase == 2'd0) |=> (seq_phase == 2'd1));

    p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!pal_acc && !idx_wr) |=> ($stable(seq_idx) && $stable(seq_phase)));

    p_rvalid_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr) |=> host_rvalid);

    p_no_read_on_clash_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_wr) |=> !host_rvalid);

    p_phase_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seq_phase != 2'd3);

endmodule

bind clut_regif clut_regif_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_sel    (host_sel),
    .host_rvalid (host_rvalid),
    .wr_byte     (wr_byte),
    .seq_idx     (seq_idx),
    .seq_phase   (seq_phase)
);

// File: tb/clut_regif_test.sv
module clut_regif_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_wr, host_rd;
    logic [1:0]  host_sel;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;
    logic        host_rvalid;
    logic [7:0]  pix_idx;
    logic [23:0] pix_rgb;

    always #(CLK_PERIOD/2) clk = ~clk;

    clut_regif uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    // reference model state
    logic [7:0]  m_r [256];
    logic [7:0]  m_g [256];
    logic [7:0]  m_b [256];
    bit          k_r [256];
    bit          k_g [256];
    bit          k_b [256];
    logic [7:0]  m_ctrl [8];
    logic [7:0]  m_curs;
    int          m_idx, m_ph;
    logic [31:0] e_rdata;
    logic        e_rvalid;
    logic [23:0] e_pix;
    bit          e_pix_ok;

    int    vectors = 0;
    int    fails   = 0;
    string cur_req = "R1";
    bit    done    = 0;

    function automatic void advance();
        if (m_ph == 2) begin
            m_ph  = 0;
            m_idx = (m_idx + 1) % 256;
        end else begin
            m_ph = m_ph + 1;
        end
    endfunction

    always @(posedge clk) begin
        int         a;
        logic [7:0] b;
        logic [23:0] nxt;
        bit          nok;
        if (!rst_n) begin
            m_idx = 0; m_ph = 0; m_curs = 8'h00;
            for (int s = 0; s < 8; s++) m_ctrl[s] = 8'h00;
            m_ctrl[4] = 8'hFF; m_ctrl[6] = 8'h73;
            e_rdata = 0; e_rvalid = 0; e_pix = 0; e_pix_ok = 1;
        end else begin
            a   = int'(pix_idx & m_ctrl[4]);
            nxt = {m_r[a], m_g[a], m_b[a]};
            nok = k_r[a] && k_g[a] && k_b[a];
            b   = host_wdata[31:24];
            e_rvalid = 0;
            if (host_wr) begin
                case (host_sel)
                    2'd0: begin m_idx = int'(b); m_ph = 0; end
                    2'd1: begin
                        if (m_ph == 0) begin m_r[m_idx] = b; k_r[m_idx] = 1; end
                        else if (m_ph == 1) begin m_g[m_idx] = b; k_g[m_idx] = 1; end
                        else begin m_b[m_idx] = b; k_b[m_idx] = 1; end
                        advance();
                    end
                    2'd2: if (m_idx < 8) m_ctrl[m_idx] = b;
                    default: m_curs = b;
                endcase
            end else if (host_rd) begin
                e_rvalid = 1;
                case (host_sel)
                    2'd0: e_rdata = {8'(m_idx), 24'h0};
                    2'd1: begin
                        if (m_ph == 0) e_rdata = {m_r[m_idx], 24'h0};
                        else if (m_ph == 1) e_rdata = {m_g[m_idx], 24'h0};
                        else e_rdata = {m_b[m_idx], 24'h0};
                        advance();
                    end
                    2'd2: e_rdata = {(m_idx < 8) ? m_ctrl[m_idx] : 8'h00, 24'h0};
                    default: e_rdata = {m_curs, 24'h0};
                endcase
            end
            e_pix    = nxt;
            e_pix_ok = nok;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            vectors++;
            if (host_rvalid !== e_rvalid) begin
                fails++;
                $display("FAIL %s host_rvalid act %b exp %b", cur_req, host_rvalid, e_rvalid);
            end
            if (host_rdata !== e_rdata) begin
                fails++;
                $display("FAIL %s host_rdata act %h exp %h", cur_req, host_rdata, e_rdata);
            end
            if (e_pix_ok && pix_rgb !== e_pix) begin
                fails++;
                $display("FAIL %s pix_rgb act %h exp %h", cur_req, pix_rgb, e_pix);
            end
        end
    end

    task automatic wr(input logic [1:0] s, input logic [7:0] b);
        host_wr = 1; host_sel = s; host_wdata = {b, 24'h5A3C96};
        @(negedge clk);
        host_wr = 0; host_wdata = 32'h00FFFFFF;
    endtask

    task automatic rd(input logic [1:0] s);
        host_rd = 1; host_sel = s;
        @(negedge clk);
        host_rd = 0;
    endtask

    function automatic logic [7:0] pat(input int i, input int c);
        return 8'((i * 7 + c * 50 + 3) ^ (i >> 3));
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired in %s", cur_req);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        rst_n = 0; host_wr = 0; host_rd = 0; host_sel = 0;
        host_wdata = 0; pix_idx = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset values of outputs and control slots
        cur_req = "R1";
        vectors++;
        if (pix_rgb !== 24'h0 || host_rvalid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset pix %h rvalid %b exp 000000 0", pix_rgb, host_rvalid);
        end
        for (int s = 4; s < 8; s++) begin wr(2'd0, 8'(s)); rd(2'd2); end
        rd(2'd3);
        // R2: index readback in top byte
        cur_req = "R2";
        rd(2'd0);
        // R4: load every entry, index wraps to 0
        cur_req = "R4";
        wr(2'd0, 8'd0);
        for (int i = 0; i < 256; i++)
            for (int c = 0; c < 3; c++) wr(2'd1, pat(i, c));
        rd(2'd0);
        rd(2'd1); rd(2'd1); rd(2'd1);
        // R5: read sequence and advance
        cur_req = "R5";
        wr(2'd0, 8'd255);
        repeat (6) rd(2'd1);
        rd(2'd0);
        // R3: index write mid-sequence
        cur_req = "R3";
        wr(2'd0, 8'd10); wr(2'd1, 8'h01); wr(2'd1, 8'h02);
        wr(2'd0, 8'd20); wr(2'd1, 8'h77);
        wr(2'd0, 8'd20); rd(2'd1);
        wr(2'd0, 8'd10); repeat (3) rd(2'd1);
        // R7: pixel sweep with full mask
        cur_req = "R7";
        for (int i = 0; i < 256; i++) begin pix_idx = 8'(i); @(negedge clk); end
        // R8: mask written on same edge as a lookup
        cur_req = "R8";
        wr(2'd0, 8'd4);
        pix_idx = 8'hF3;
        wr(2'd2, 8'h0F);
        for (int i = 0; i < 40; i++) begin pix_idx = 8'(i * 13); @(negedge clk); end
        wr(2'd2, 8'hFF);
        @(negedge clk);
        // R9: palette write and lookup of the same entry together
        cur_req = "R9";
        pix_idx = 8'd30;
        wr(2'd0, 8'd30);
        wr(2'd1, 8'hEE);
        @(negedge clk);
        wr(2'd1, 8'h11);
        repeat (2) @(negedge clk);
        // R10: write and read strobes together
        cur_req = "R10";
        host_wr = 1; host_rd = 1; host_sel = 2'd3; host_wdata = {8'h9D, 24'h0};
        @(negedge clk);
        host_wr = 0; host_rd = 0;
        rd(2'd3);
        // R6: control slots, out-of-range index, no index motion
        cur_req = "R6";
        wr(2'd0, 8'd9); wr(2'd2, 8'h55); rd(2'd2); rd(2'd0);
        wr(2'd0, 8'd6); rd(2'd2); wr(2'd2, 8'h3A); rd(2'd2); rd(2'd0);
        wr(2'd0, 8'd2); wr(2'd1, 8'h42); wr(2'd2, 8'h00); wr(2'd1, 8'h43); rd(2'd0);
        // R11: cursor register
        cur_req = "R11";
        wr(2'd3, 8'hC4); rd(2'd3);
        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule